// File: doc/BRIEF.md
# Sub-Processor Reset and Interrupt Control

This block is the control register that a main processor uses to govern a subordinate processor. Writes into its low byte move the sub processor through reset, halt and run, and decide whether the main side may reach the sub processor's program RAM. Writes into its high byte ask for a level-2 interrupt toward the sub processor. The request only takes effect when the sub side has enabled that level in its own mask.

Control writes are handled as follows. The reset output is a single-cycle pulse. It fires only when a write sets the stored reset bit and that bit was clear before. A write that clears the reset bit always halts the sub processor and leaves the bus-request bit set. While the sub processor reports itself stopped, the stored bus-request bit is forced to zero. The program RAM grant copies the stored bus-request bit, but only on control writes that change the halt level. Interrupt requests made while the level is masked are dropped. A pending interrupt stays until the sub side acknowledges it.

Top module: `subcpu_ctl`

## Requirements
- R1: After a synchronous active-low reset, the readback is 0x0002, with reset bit (bit 0) = 0 and bus-request bit (bit 1) = 1. Halt and program RAM grant are 1. The reset pulse, interrupt flag and interrupt level are 0.
- R2: A control write with data bit 0 = 1 produces `sub_reset_pulse` high for exactly one cycle, but only if the stored reset bit was 0 before the write. Otherwise no pulse is produced.
- R3: A control write with data bit 0 = 1 stores data bits 1:0 into the reset and bus-request bits, and sets `sub_halt` equal to data bit 1.
- R4: A control write with data bit 0 = 0 sets `sub_halt` to 1 and stores 0b10 (reset 0, bus request 1), whatever data bit 1 holds.
- R5: A control write made while `sub_stopped` is 1 stores the bus-request bit as 0.
- R6: On a control write that changes `sub_halt`, `prg_access_en` takes the newly stored bus-request bit. At all other times `prg_access_en` keeps its value.
- R7: An interrupt write with interrupt data bit (bit 8) = 1 sets the interrupt flag and pending level 2, but only when `irq_mask` bit 2 is 1. With the mask bit clear, or the data bit 0, nothing changes.
- R8: `irq_level` equals the pending bits ANDed with `irq_mask`, shifted right by one, so a pending level 2 shows as 0x02. The output follows mask changes in the same cycle.
- R9: `irq_ack` clears the interrupt flag and pending level 2. A set and an acknowledge in the same cycle leave the flag set.
- R10: A byte write to the low lane (`wr_word` = 0, `wr_hi` = 0) acts only as a control write. A byte write to the high lane acts only as an interrupt write. A word write acts as both. Readback places the flag at bit 8, bus request at bit 1 and reset at bit 0, and all other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_word | input | 1 | 1 = word write (both lanes) |
| wr_hi | input | 1 | Byte lane select when `wr_word` = 0 (1 = high lane) |
| wr_data | input | 16 | Write data in word layout |
| irq_mask | input | 8 | Sub-side interrupt enable mask |
| sub_stopped | input | 1 | Sub processor reports its stopped state |
| irq_ack | input | 1 | Sub-side acknowledge of the pending level-2 interrupt |
| rd_data | output | 16 | Register readback |
| sub_reset_pulse | output | 1 | One-cycle reset pulse to the sub processor |
| sub_halt | output | 1 | Halt level to the sub processor |
| prg_access_en | output | 1 | Main-side program RAM access grant |
| irq_flag | output | 1 | Interrupt-request flag |
| irq_level | output | 7 | Pending interrupt levels after masking, shifted right by one |

## Verification
Everything a write or an acknowledge changes appears one cycle later: the stored bits, readback, halt, grant, flag and the reset pulse. The reset pulse drops again one cycle after that. `irq_level` responds to `irq_mask` with no clock edge at all. The bench drives each stimulus on the falling edge and checks 1 ns after the next rising edge. It checks mask effects 1 ns after changing the mask, and confirms that the pulse is gone one full cycle later.

// File: rtl/subcpu_ctl_pkg.sv
// Package: bit positions and the control field type shared by the
// sub-processor control register and its checker.
package subcpu_ctl_pkg;
    localparam int RST_BIT    = 0;  // reset bit in the low lane
    localparam int BREQ_BIT   = 1;  // bus-request bit in the low lane
    localparam int IRQ_BIT    = 8;  // interrupt request bit (high lane bit 0)
    localparam int LEVEL2_IDX = 2;  // pending/mask index of level 2

    typedef struct packed {
        logic busreq;
        logic rst;
    } ctrl_bits_t;
endpackage

// File: rtl/subcpu_ctl_reg.sv
// Module: control half of the register. Holds reset and bus-request bits,
// drives halt, the one-cycle reset pulse and the program RAM grant.
// Assumes wr is already qualified to control-lane writes.
module subcpu_ctl_reg
    import subcpu_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [1:0] d,
    input  logic       stopped,
    output ctrl_bits_t bits,
    output logic       halt,
    output logic       pulse,
    output logic       prg_en
);
    ctrl_bits_t bits_q, bits_n;
    logic       halt_q, halt_n, pulse_q, prg_q;

    // Next-state of the stored bits and halt level for a control write.
    always_comb begin
        if (d[0]) begin
            bits_n.rst    = 1'b1;
            bits_n.busreq = d[1];
            halt_n        = d[1];
        end else begin
            bits_n.rst    = 1'b0;
            bits_n.busreq = 1'b1;
            halt_n        = 1'b1;
        end
        if (stopped) begin
            bits_n.busreq = 1'b0;
        end
    end

    // State update: stored bits, halt, reset edge pulse and RAM grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q  <= '{busreq: 1'b1, rst: 1'b0};
            halt_q  <= 1'b1;
            pulse_q <= 1'b0;
            prg_q   <= 1'b1;
        end else begin
            pulse_q <= wr && d[0] && !bits_q.rst;
            if (wr) begin
                bits_q <= bits_n;
                halt_q <= halt_n;
                if (halt_n != halt_q) begin
                    prg_q <= bits_n.busreq;
                end
            end
        end
    end

    assign bits   = bits_q;
    assign halt   = halt_q;
    assign pulse  = pulse_q;
    assign prg_en = prg_q;
endmodule

// File: rtl/subcpu_irq.sv
// Module: interrupt half. Sets the flag and the pending level-2 bit on an
// enabled request, clears both on acknowledge (set wins), and forms the
// masked, shifted level vector. Assumes IRQ_W > LEVEL2_IDX.
module subcpu_irq
    import subcpu_ctl_pkg::*;
#(
    parameter int IRQ_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             ack,
    input  logic [IRQ_W-1:0] mask,
    output logic             flag,
    output logic [IRQ_W-2:0] level
);
    logic [IRQ_W-1:0] pend_q;
    logic             flag_q;
    logic             take;

    // A request counts only while level 2 is enabled.
    always_comb take = req && mask[LEVEL2_IDX];

    // Flag and pending update; a same-cycle set overrides acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            flag_q <= 1'b0;
        end else if (take) begin
            pend_q[LEVEL2_IDX] <= 1'b1;
            flag_q             <= 1'b1;
        end else if (ack) begin
            pend_q[LEVEL2_IDX] <= 1'b0;
            flag_q             <= 1'b0;
        end
    end

    // Masked pending vector, dropping bit 0.
    always_comb begin
        logic [IRQ_W-1:0] masked;
        masked = pend_q & mask;
        level  = masked[IRQ_W-1:1];
    end

    assign flag = flag_q;
endmodule

// File: rtl/subcpu_ctl.sv
// Module: top of the sub-processor control register. Decodes byte/word
// lanes into control and interrupt writes and assembles the readback.
// Assumes the word layout: low lane control, high lane interrupt.
module subcpu_ctl
    import subcpu_ctl_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IRQ_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_word,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IRQ_W-1:0]  irq_mask,
    input  logic              sub_stopped,
    input  logic              irq_ack,
    output logic [DATA_W-1:0] rd_data,
    output logic              sub_reset_pulse,
    output logic              sub_halt,
    output logic              prg_access_en,
    output logic              irq_flag,
    output logic [IRQ_W-2:0]  irq_level
);
    logic       ctrl_wr, irq_wr;
    ctrl_bits_t bits;

    // Lane decode: which halves this write touches.
    always_comb begin
        ctrl_wr = wr_en && (wr_word || !wr_hi);
        irq_wr  = wr_en && (wr_word ||  wr_hi);
    end

    subcpu_ctl_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (ctrl_wr),
        .d       (wr_data[BREQ_BIT:RST_BIT]),
        .stopped (sub_stopped),
        .bits    (bits),
        .halt    (sub_halt),
        .pulse   (sub_reset_pulse),
        .prg_en  (prg_access_en)
    );

    subcpu_irq #(.IRQ_W(IRQ_W)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (irq_wr && wr_data[IRQ_BIT]),
        .ack   (irq_ack),
        .mask  (irq_mask),
        .flag  (irq_flag),
        .level (irq_level)
    );

    // Readback assembly.
    always_comb begin
        rd_data           = '0;
        rd_data[RST_BIT]  = bits.rst;
        rd_data[BREQ_BIT] = bits.busreq;
        rd_data[IRQ_BIT]  = irq_flag;
    end
endmodule

// File: rtl/subcpu_ctl_chk.sv
// Module: property checker for subcpu_ctl, attached by bind below.
// Assumes the package bit positions and IRQ_W > 2.
module subcpu_ctl_chk
    import subcpu_ctl_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IRQ_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              wr_word,
    input logic              wr_hi,
    input logic [DATA_W-1:0] wr_data,
    input logic [IRQ_W-1:0]  irq_mask,
    input logic              sub_stopped,
    input logic              irq_ack,
    input logic [DATA_W-1:0] rd_data,
    input logic              sub_reset_pulse,
    input logic              sub_halt,
    input logic              prg_access_en,
    input logic              irq_flag,
    input logic [IRQ_W-2:0]  irq_level
);
    logic ctl_w, irq_w;
    assign ctl_w = wr_en && (wr_word || !wr_hi);
    assign irq_w = wr_en && (wr_word ||  wr_hi) && wr_data[IRQ_BIT];

    p_pulse_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sub_reset_pulse |=> !sub_reset_pulse);

    p_pulse_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_w && wr_data[RST_BIT] && !rd_data[RST_BIT]) |=> sub_reset_pulse);

    p_run_follows_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_w && wr_data[RST_BIT]) |=> (sub_halt == $past(wr_data[BREQ_BIT])));

    p_zero_forces_halt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_w && !wr_data[RST_BIT]) |=> (sub_halt && !rd_data[RST_BIT]));

    p_stopped_clears_busreq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_w && sub_stopped) |=> !rd_data[BREQ_BIT]);

    p_grant_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_w |=> $stable(prg_access_en));

    p_masked_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_w && !irq_mask[LEVEL2_IDX] && !irq_flag && !irq_ack) |=> !irq_flag);

    p_level_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_mask[LEVEL2_IDX] |-> (irq_level == '0));

    p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !(irq_w && irq_mask[LEVEL2_IDX])) |=> !irq_flag);

    p_readback_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(rd_data) <= 3) && (rd_data[IRQ_BIT] == irq_flag));
endmodule

bind subcpu_ctl subcpu_ctl_chk #(.DATA_W(DATA_W), .IRQ_W(IRQ_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .wr_en           (wr_en),
    .wr_word         (wr_word),
    .wr_hi           (wr_hi),
    .wr_data         (wr_data),
    .irq_mask        (irq_mask),
    .sub_stopped     (sub_stopped),
    .irq_ack         (irq_ack),
    .rd_data         (rd_data),
    .sub_reset_pulse (sub_reset_pulse),
    .sub_halt        (sub_halt),
    .prg_access_en   (prg_access_en),
    .irq_flag        (irq_flag),
    .irq_level       (irq_level)
);

// File: tb/subcpu_ctl_bench.sv
// Directed bench for subcpu_ctl: one task per scenario, each checking its
// own results one cycle after the stimulus edge.
module subcpu_ctl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, wr_word = 1'b0, wr_hi = 1'b0;
    logic [15:0] wr_data = '0;
    logic [7:0]  irq_mask = '0;
    logic        sub_stopped = 1'b0, irq_ack = 1'b0;
    logic [15:0] rd_data;
    logic        sub_reset_pulse, sub_halt, prg_access_en, irq_flag;
    logic [6:0]  irq_level;
    int          n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    subcpu_ctl u_subcpu_ctl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word),
        .wr_hi(wr_hi), .wr_data(wr_data), .irq_mask(irq_mask),
        .sub_stopped(sub_stopped), .irq_ack(irq_ack), .rd_data(rd_data),
        .sub_reset_pulse(sub_reset_pulse), .sub_halt(sub_halt),
        .prg_access_en(prg_access_en), .irq_flag(irq_flag),
        .irq_level(irq_level)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Apply one write (and optional ack) then sample after the next edge.
    task automatic put(input logic word, input logic hi, input logic [15:0] d,
                       input logic ack);
        @(negedge clk);
        wr_en = 1'b1; wr_word = word; wr_hi = hi; wr_data = d; irq_ack = ack;
        @(posedge clk);
        #1;
        wr_en = 1'b0; irq_ack = 1'b0;
    endtask

    task automatic ctl_state(input string req, input logic [15:0] rd,
                             input logic halt, input logic prg, input logic pls);
        chk(req, "rd_data", rd_data, rd);
        chk(req, "halt", sub_halt, halt);
        chk(req, "prg_en", prg_access_en, prg);
        chk(req, "pulse", sub_reset_pulse, pls);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        ctl_state("R1", 16'h0002, 1'b1, 1'b1, 1'b0);
        chk("R1", "flag", irq_flag, 0);
        chk("R1", "level", irq_level, 0);
    endtask

    task automatic t_release_and_repeat;
        put(1'b1, 1'b0, 16'h0001, 1'b0);
        ctl_state("R2", 16'h0001, 1'b0, 1'b0, 1'b1);
        @(posedge clk); #1;
        chk("R2", "pulse gone", sub_reset_pulse, 0);
        put(1'b1, 1'b0, 16'h0001, 1'b0);
        ctl_state("R2", 16'h0001, 1'b0, 1'b0, 1'b0);
        put(1'b1, 1'b0, 16'h0003, 1'b0);
        ctl_state("R3", 16'h0003, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_zero_write;
        put(1'b0, 1'b0, 16'h0000, 1'b0);
        ctl_state("R4", 16'h0002, 1'b1, 1'b1, 1'b0);
        put(1'b0, 1'b0, 16'h0001, 1'b0);
        ctl_state("R3", 16'h0001, 1'b0, 1'b0, 1'b1);
        put(1'b0, 1'b0, 16'h0002, 1'b0);
        ctl_state("R4", 16'h0002, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_stopped;
        sub_stopped = 1'b1;
        put(1'b1, 1'b0, 16'h0003, 1'b0);
        ctl_state("R5", 16'h0001, 1'b1, 1'b1, 1'b1);
        put(1'b1, 1'b0, 16'h0001, 1'b0);
        ctl_state("R6", 16'h0001, 1'b0, 1'b0, 1'b0);
        put(1'b1, 1'b0, 16'h0000, 1'b0);
        ctl_state("R5", 16'h0000, 1'b1, 1'b0, 1'b0);
        sub_stopped = 1'b0;
        put(1'b1, 1'b0, 16'h0000, 1'b0);
        ctl_state("R6", 16'h0002, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_irq;
        irq_mask = 8'h00;
        put(1'b1, 1'b0, 16'h0100, 1'b0);
        chk("R7", "masked flag", irq_flag, 0);
        chk("R7", "masked level", irq_level, 0);
        chk("R7", "masked rd", rd_data, 16'h0002);
        irq_mask = 8'h04;
        put(1'b0, 1'b1, 16'h0000, 1'b0);
        chk("R7", "zero bit flag", irq_flag, 0);
        put(1'b0, 1'b1, 16'h0100, 1'b0);
        chk("R7", "set flag", irq_flag, 1);
        chk("R10", "hi lane rd", rd_data, 16'h0102);
        chk("R8", "level", irq_level, 7'h02);
        @(negedge clk); irq_mask = 8'h00; #1;
        chk("R8", "mask off level", irq_level, 0);
        chk("R8", "flag kept", irq_flag, 1);
        irq_mask = 8'hFF; #1;
        chk("R8", "full mask level", irq_level, 7'h02);
    endtask

    task automatic t_ack;
        @(negedge clk); irq_ack = 1'b1;
        @(posedge clk); #1; irq_ack = 1'b0;
        chk("R9", "ack flag", irq_flag, 0);
        chk("R9", "ack level", irq_level, 0);
        irq_mask = 8'h04;
        put(1'b0, 1'b1, 16'h0100, 1'b1);
        chk("R9", "set beats ack", irq_flag, 1);
        @(negedge clk); irq_ack = 1'b1;
        @(posedge clk); #1; irq_ack = 1'b0;
        chk("R9", "ack again", irq_flag, 0);
    endtask

    task automatic t_lanes;
        put(1'b0, 1'b0, 16'h0103, 1'b0);
        chk("R10", "low lane no irq", irq_flag, 0);
        ctl_state("R10", 16'h0003, 1'b1, 1'b0, 1'b1);
        put(1'b1, 1'b0, 16'h0103, 1'b0);
        chk("R10", "word both flag", irq_flag, 1);
        ctl_state("R10", 16'h0103, 1'b1, 1'b0, 1'b0);
    endtask

    initial begin
        t_reset();
        t_release_and_repeat();
        t_zero_write();
        t_stopped();
        t_irq();
        t_ack();
        t_lanes();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule